// File: doc/BRIEF.md
# Reset Pin Glitch Filter

This block sits between an active-low external reset pin and the chip's reset sequencing logic. It turns the raw, possibly noisy pin into a clean, active-high reset request. The pin is always passed through a synchronizer first. After that, one of three paths drives the request. The bypass path follows the synchronized pin directly. The fast filter counts enable ticks of the bus clock and has a programmable length. The slow filter counts enable ticks of a low-power oscillator and has a fixed length.

The path is chosen per power mode from a small byte-wide configuration space. A two-bit field picks the path for run and wait. A separate bit picks between bypass and the slow filter while the chip is stopped. A five-bit field sets the fast filter length. The configuration is cleared only by the chip power-on reset. A warm reset clears the filter state and the synchronizer, but the settings are kept.

Each filter holds its output until the synchronized pin has shown a different level on a configured number of consecutive ticks of its own clock enable. The fast filter is cleared whenever it is not the selected path, which includes entry into stop. The slow filter is cleared whenever it is not the selected path and also on entry into a low-leakage stop mode.

Top module: `pin_reset_filter`

## Requirements
- R1: The control register sits at byte offset 4 and uses bits 2:0. The width register sits at offset 5 and uses bits 4:0. Writes take effect at the next clock edge. Reads are combinational. Unused bits and every other offset read as 0.
- R2: Chip power-on reset (por_n low) clears both registers to 0. With the registers at 0, the request follows the pin through the bypass path.
- R3: A warm reset (warm_rst_n low for one clock edge) leaves both registers unchanged. It returns both filters to the idle state, where no request is issued.
- R4: In run mode, control bits 1:0 equal to 00, or to the reserved value 11, select the bypass path. In this path rst_req is the inverted pin after two synchronizer flops.
- R5: In run mode, control bits 1:0 equal to 01 select the bus filter. Its output takes the new pin level on the (width field + 1)-th consecutive bus tick that sees that level, so the length runs from 1 to 32 ticks.
- R6: In run mode, control bits 1:0 equal to 10 select the low-power filter. Its length is fixed at 3 consecutive low-power ticks.
- R7: While stop_mode is high, control bit 2 selects the path: 1 for the low-power filter, 0 for bypass. Bits 1:0 are ignored in stop. Bit 2 is ignored in run.
- R8: A tick that samples the level the filter already outputs restarts the count. The same rule applies when the request is asserted and when it is released.
- R9: The bus filter is cleared on any clock where it is not the selected path. This covers entry into stop and a write that selects another path.
- R10: The low-power filter is cleared on entry into a low-leakage stop, where lowleak_mode rises while stop_mode is high. It is also cleared on any clock where it is not selected. Entering plain stop with bit 2 set keeps its count.
- R11: Ticks of the clock enable that is not selected have no effect on rst_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Chip power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | Any other reset, active low, synchronous |
| reset_pin_n | input | 1 | Raw external reset pin, active low |
| bus_tick | input | 1 | Bus-clock filter enable tick |
| lpo_tick | input | 1 | Low-power oscillator filter enable tick |
| stop_mode | input | 1 | High while the chip is in a stop mode |
| lowleak_mode | input | 1 | High while that stop mode is a low-leakage one |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| rst_req | output | 1 | Filtered reset request, active high |

## Verification
Two functions can act in the same cycle: a filter counting toward its threshold, and the clearing of that filter. The clear can come from a mode entry, a deselection or a warm reset. The bench brings a filter to one tick short of its threshold. It then raises stop, raises lowleak_mode, rewrites the path select or pulses warm reset, and applies one more tick. It judges the result by whether rst_req stays low for the full count again. It also checks the opposite case: entering plain stop while the low-power filter stays selected must keep the partial count.

// File: rtl/pinflt_pkg.sv
package pinflt_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CTRL_W = 3;

    typedef enum logic [1:0] {
        SRC_PIN = 2'd0,
        SRC_BUS = 2'd1,
        SRC_LPO = 2'd2
    } flt_src_e;

    // Path choice: the stop-mode bit rules in stop, the two-bit field rules otherwise.
    function automatic flt_src_e pick_src(input logic [CTRL_W-1:0] ctrl, input logic in_stop);
        flt_src_e s;
        if (in_stop) begin
            s = ctrl[2] ? SRC_LPO : SRC_PIN;
        end else begin
            case (ctrl[1:0])
                2'b01:   s = SRC_BUS;
                2'b10:   s = SRC_LPO;
                default: s = SRC_PIN;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/pinflt_cfg.sv
module pinflt_cfg
    import pinflt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 3,
    parameter int unsigned CTRL_OFS = 4,
    parameter int unsigned WID_OFS  = 5,
    parameter int unsigned WID_W    = 5
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [WID_W-1:0]    wid_o
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_WID  = ADDR_W'(WID_OFS);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [WID_W-1:0]  wid;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && addr == A_CTRL) cfg_d.ctrl = wdata[CTRL_W-1:0];
        if (wr_en && addr == A_WID)  cfg_d.wid  = wdata[WID_W-1:0];
    end

    // Only the power-on reset touches the configuration.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL)     rdata[CTRL_W-1:0] = cfg_q.ctrl;
        else if (addr == A_WID) rdata[WID_W-1:0]  = cfg_q.wid;
    end

    assign ctrl_o = cfg_q.ctrl;
    assign wid_o  = cfg_q.wid;

    // R1
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(wr_en && addr == A_CTRL) |=> $stable(cfg_q.ctrl));

    // R1
    wid_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(wr_en && addr == A_WID) |=> $stable(cfg_q.wid));

endmodule

// File: rtl/pinflt_sync.sv
module pinflt_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        IDLE_LV = 1'b1
) (
    input  logic clk,
    input  logic por_n,
    input  logic warm_rst_n,
    input  logic d_i,
    output logic q_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d = sy_q;
        if (!warm_rst_n) sy_d.sh = {STAGES{IDLE_LV}};
        else             sy_d.sh = {sy_q.sh[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sy_q.sh <= {STAGES{IDLE_LV}};
        else        sy_q    <= sy_d;
    end

    assign q_o = sy_q.sh[STAGES-1];

    // R4
    sync_step_chk: assert property (@(posedge clk) disable iff (!por_n)
        warm_rst_n |=> q_o == $past(sy_q.sh[STAGES-2]));

endmodule

// File: rtl/pinflt_count.sv
module pinflt_count #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             sample_i,
    input  logic [CNT_W-1:0] need_i,
    output logic             level_o
);

    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] cnt;
    } flt_t;

    flt_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (clr_i) begin
            f_d.level = 1'b1;
            f_d.cnt   = '0;
        end else if (tick_i) begin
            if (sample_i == f_q.level) begin
                f_d.cnt = '0;
            end else if (f_q.cnt + CNT_W'(1) >= need_i) begin
                f_d.level = sample_i;
                f_d.cnt   = '0;
            end else begin
                f_d.cnt = f_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            f_q.level <= 1'b1;
            f_q.cnt   <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign level_o = f_q.level;

    // R9 R10
    clr_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        clr_i |=> (level_o && f_q.cnt == '0));

    // R11
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!clr_i && !tick_i) |=> $stable(level_o));

    // R8
    agree_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!clr_i && tick_i && sample_i == level_o) |=> (f_q.cnt == '0 && $stable(level_o)));

endmodule

// File: rtl/pin_reset_filter.sv
module pin_reset_filter
    import pinflt_pkg::*;
#(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned CTRL_OFS    = 4,
    parameter int unsigned WID_OFS     = 5,
    parameter int unsigned WID_W       = 5,
    parameter int unsigned LPO_TICKS   = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst_n,
    input  logic              reset_pin_n,
    input  logic              bus_tick,
    input  logic              lpo_tick,
    input  logic              stop_mode,
    input  logic              lowleak_mode,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              rst_req
);

    localparam int unsigned CNT_W = $clog2((1 << WID_W) + 1);
    localparam logic [CNT_W-1:0] LPO_NEED = CNT_W'(LPO_TICKS);

    typedef struct packed {
        logic stop;
        logic lleak;
    } mode_t;

    mode_t mode_d, mode_q;

    logic [CTRL_W-1:0] ctrl;
    logic [WID_W-1:0]  wid;
    logic              pin_s;
    logic              bus_lvl, lpo_lvl;
    logic              stop_entry, lleak_now, lleak_entry;
    logic              bus_clr, lpo_clr;
    logic [CNT_W-1:0]  bus_need;
    flt_src_e          src;

    pinflt_cfg #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFS (CTRL_OFS),
        .WID_OFS  (WID_OFS),
        .WID_W    (WID_W)
    ) u_cfg (
        .clk    (clk),
        .por_n  (por_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .ctrl_o (ctrl),
        .wid_o  (wid)
    );

    pinflt_sync #(
        .STAGES  (SYNC_STAGES),
        .IDLE_LV (1'b1)
    ) u_sync (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .d_i        (reset_pin_n),
        .q_o        (pin_s)
    );

    // Mode-entry detection.
    always_comb begin
        lleak_now    = stop_mode && lowleak_mode;
        stop_entry   = stop_mode && !mode_q.stop;
        lleak_entry  = lleak_now && !mode_q.lleak;
        mode_d.stop  = stop_mode;
        mode_d.lleak = lleak_now;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    always_comb begin
        src      = pick_src(ctrl, stop_mode);
        bus_need = CNT_W'(wid) + CNT_W'(1);
        bus_clr  = !warm_rst_n || src != SRC_BUS || stop_entry;
        lpo_clr  = !warm_rst_n || src != SRC_LPO || lleak_entry;
    end

    pinflt_count #(.CNT_W(CNT_W)) u_bus_flt (
        .clk      (clk),
        .por_n    (por_n),
        .clr_i    (bus_clr),
        .tick_i   (bus_tick),
        .sample_i (pin_s),
        .need_i   (bus_need),
        .level_o  (bus_lvl)
    );

    pinflt_count #(.CNT_W(CNT_W)) u_lpo_flt (
        .clk      (clk),
        .por_n    (por_n),
        .clr_i    (lpo_clr),
        .tick_i   (lpo_tick),
        .sample_i (pin_s),
        .need_i   (LPO_NEED),
        .level_o  (lpo_lvl)
    );

    always_comb begin
        case (src)
            SRC_BUS: rst_req = !bus_lvl;
            SRC_LPO: rst_req = !lpo_lvl;
            default: rst_req = !pin_s;
        endcase
    end

    // R5 R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (src == SRC_BUS && !bus_tick && warm_rst_n) |=> (src != SRC_BUS || $stable(rst_req)));

    // R6 R11
    lpo_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (src == SRC_LPO && !lpo_tick && warm_rst_n && !lleak_entry)
            |=> (src != SRC_LPO || $stable(rst_req)));

    // R2
    por_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> (ctrl == '0 && wid == '0));

endmodule

// File: tb/tb_pin_reset_filter.sv
module tb_pin_reset_filter;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0] ctrl;
        logic [4:0] wid;
        logic       stop;
        logic       ll;
        logic [1:0] path;   // 0 bypass, 1 bus filter, 2 low-power filter
        logic [5:0] n;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{3'd0, 5'd5,  1'b0, 1'b0, 2'd0, 6'd0},
        '{3'd3, 5'd5,  1'b0, 1'b0, 2'd0, 6'd0},
        '{3'd1, 5'd0,  1'b0, 1'b0, 2'd1, 6'd1},
        '{3'd1, 5'd7,  1'b0, 1'b0, 2'd1, 6'd8},
        '{3'd1, 5'd31, 1'b0, 1'b0, 2'd1, 6'd32},
        '{3'd2, 5'd4,  1'b0, 1'b0, 2'd2, 6'd3},
        '{3'd4, 5'd0,  1'b1, 1'b0, 2'd2, 6'd3},
        '{3'd1, 5'd9,  1'b1, 1'b0, 2'd0, 6'd0},
        '{3'd6, 5'd0,  1'b1, 1'b1, 2'd2, 6'd3},
        '{3'd5, 5'd2,  1'b0, 1'b0, 2'd1, 6'd3}
    };

    logic clk = 1'b0;
    logic por_n, warm_rst_n, pin_n, bt, lt, stop, ll, wr;
    logic [2:0] addr;
    logic [7:0] wdata, rdata;
    logic rst_req;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_reset_filter dut (
        .clk          (clk),
        .por_n        (por_n),
        .warm_rst_n   (warm_rst_n),
        .reset_pin_n  (pin_n),
        .bus_tick     (bt),
        .lpo_tick     (lt),
        .stop_mode    (stop),
        .lowleak_mode (ll),
        .reg_wr       (wr),
        .reg_addr     (addr),
        .reg_wdata    (wdata),
        .reg_rdata    (rdata),
        .rst_req      (rst_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input string tag, input logic [2:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic warm();
        warm_rst_n = 1'b0;
        @(negedge clk);
        warm_rst_n = 1'b1;
    endtask

    // sel 1 pulses the bus tick, sel 2 the low-power tick, one per cycle
    task automatic ticks(input int sel, input int k);
        for (int i = 0; i < k; i++) begin
            if (sel == 1) bt = 1'b1; else lt = 1'b1;
            @(negedge clk);
        end
        if (sel == 1) bt = 1'b0; else lt = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; warm_rst_n = 1'b1; pin_n = 1'b1; bt = 0; lt = 0;
        stop = 0; ll = 0; wr = 0; addr = '0; wdata = '0;
        cyc(2);
        por_n = 1'b1;
        cyc(1);

        // R2 reset state
        rreg("R2 ctrl after por", 3'd4, 8'h00);
        rreg("R2 width after por", 3'd5, 8'h00);
        chk("R2 idle request", {7'd0, rst_req}, 8'h00);
        pin_n = 1'b0; cyc(2);
        chk("R2 bypass after por", {7'd0, rst_req}, 8'h01);
        pin_n = 1'b1; cyc(2);
        chk("R2 bypass release", {7'd0, rst_req}, 8'h00);

        // R1 masks and decode
        wreg(3'd4, 8'hFF); rreg("R1 ctrl mask", 3'd4, 8'h07);
        wreg(3'd5, 8'hFF); rreg("R1 width mask", 3'd5, 8'h1F);
        rreg("R1 empty offset 6", 3'd6, 8'h00);
        rreg("R1 empty offset 0", 3'd0, 8'h00);

        // R3 warm reset keeps configuration, por clears it
        wreg(3'd4, 8'h02); wreg(3'd5, 8'h09);
        warm();
        rreg("R3 ctrl kept", 3'd4, 8'h02);
        rreg("R3 width kept", 3'd5, 8'h09);
        por_n = 1'b0; cyc(1); por_n = 1'b1; cyc(1);
        rreg("R2 ctrl cleared", 3'd4, 8'h00);
        rreg("R2 width cleared", 3'd5, 8'h00);

        // Table walk: R4 R5 R6 R7 R11
        foreach (VECS[v]) begin
            bt = 0; lt = 0; pin_n = 1'b1;
            stop = VECS[v].stop; ll = VECS[v].ll;
            wreg(3'd4, {5'd0, VECS[v].ctrl});
            wreg(3'd5, {3'd0, VECS[v].wid});
            warm();
            cyc(2);
            pin_n = 1'b0;
            if (VECS[v].path != 2'd1) bt = 1'b1;
            if (VECS[v].path != 2'd2) lt = 1'b1;
            cyc(2);
            if (VECS[v].path == 2'd0) begin
                chk($sformatf("R4/R7 bypass vec %0d", v), {7'd0, rst_req}, 8'h01);
            end else begin
                chk($sformatf("R11 no early request vec %0d", v), {7'd0, rst_req}, 8'h00);
                ticks(VECS[v].path, VECS[v].n - 1);
                chk($sformatf("R5/R6 one short vec %0d", v), {7'd0, rst_req}, 8'h00);
                ticks(VECS[v].path, 1);
                chk($sformatf("R5/R6/R7 at count vec %0d", v), {7'd0, rst_req}, 8'h01);
            end
            bt = 0; lt = 0;
        end

        // R8 glitch restarts the count, bus filter length 4
        stop = 0; ll = 0; pin_n = 1'b1;
        wreg(3'd4, 8'h01); wreg(3'd5, 8'h03);
        warm(); cyc(2);
        pin_n = 1'b0; cyc(2);
        ticks(1, 3);
        pin_n = 1'b1; cyc(2);
        ticks(1, 1);
        pin_n = 1'b0; cyc(2);
        ticks(1, 3);
        chk("R8 restart after glitch", {7'd0, rst_req}, 8'h00);
        ticks(1, 1);
        chk("R8 assert after full run", {7'd0, rst_req}, 8'h01);
        pin_n = 1'b1; cyc(2);
        ticks(1, 3);
        chk("R8 release one short", {7'd0, rst_req}, 8'h01);
        ticks(1, 1);
        chk("R8 release at count", {7'd0, rst_req}, 8'h00);

        // R3 warm reset clears an asserted filter
        pin_n = 1'b0; cyc(2);
        ticks(1, 4);
        chk("R3 asserted before warm", {7'd0, rst_req}, 8'h01);
        warm();
        chk("R3 warm clears filter", {7'd0, rst_req}, 8'h00);

        // R9 stop entry clears the bus filter
        pin_n = 1'b1; warm(); cyc(2);
        pin_n = 1'b0; cyc(2);
        ticks(1, 3);
        stop = 1'b1; cyc(1);
        stop = 1'b0; cyc(1);
        ticks(1, 1);
        chk("R9 stop entry cleared count", {7'd0, rst_req}, 8'h00);
        ticks(1, 3);
        chk("R9 full count after stop", {7'd0, rst_req}, 8'h01);

        // R9 deselect by write clears the bus filter
        pin_n = 1'b1; warm(); cyc(2);
        pin_n = 1'b0; cyc(2);
        ticks(1, 3);
        wreg(3'd4, 8'h00); wreg(3'd4, 8'h01);
        ticks(1, 1);
        chk("R9 deselect cleared count", {7'd0, rst_req}, 8'h00);

        // R10 plain stop keeps the low-power count when bit 2 is set
        pin_n = 1'b1; stop = 0; ll = 0;
        wreg(3'd4, 8'h06);
        warm(); cyc(2);
        pin_n = 1'b0; cyc(2);
        ticks(2, 2);
        stop = 1'b1; cyc(1);
        ticks(2, 1);
        chk("R10 plain stop keeps count", {7'd0, rst_req}, 8'h01);

        // R10 low-leakage entry clears the low-power filter
        pin_n = 1'b1; warm(); cyc(2);
        pin_n = 1'b0; cyc(2);
        ticks(2, 2);
        ll = 1'b1; cyc(1);
        ticks(2, 1);
        chk("R10 lowleak entry cleared", {7'd0, rst_req}, 8'h00);
        ticks(2, 2);
        chk("R10 full count after lowleak", {7'd0, rst_req}, 8'h01);

        done = 1;
        summary();
        $finish;
    end

endmodule